// File: doc/BRIEF.md
# Serial Byte Receiver with Centred Bit Sampling

This block receives asynchronous serial characters on a single line. It runs from a master clock at sixteen times the bit rate. While the line is idle it stays high. A falling edge puts the receiver into a start-confirmation phase. A start bit is accepted only if the line then stays low for half a bit time. After that, a divided baud strobe samples every later bit at its midpoint. Each character has one low start bit, eight data bits sent least significant first, one parity bit and one high stop bit.

Once the whole character is in the shift register, the byte moves to a holding register and the ready flag is raised. The parity, framing and overrun flags are updated at the same time. A host fetches the byte with an active-low read strobe. The byte appears on the read-data output one cycle after the strobe falls, and the same falling edge clears the ready flag and all error flags.

Top module: `serial_rx_core`

## Requirements
- R1: While reset is high, and in the cycle after it falls, read data is 0 and the ready, parity, framing and overrun flags are all 0.
- R2: An idle receiver starts a character only on a high-to-low transition of the line. A line that is already low, for example after a character with a low stop bit, starts nothing until it has gone high and then low again.
- R3: If the line goes high again before 8 consecutive low samples have been taken, the start is abandoned. No byte is delivered, and the next valid character is received normally.
- R4: The 8th consecutive low sample counts as the start-bit sample. Every later bit is sampled exactly 16 master cycles after the one before it. Data bits arrive least significant first and form the delivered byte.
- R5: The ready flag rises one master cycle after the stop bit is sampled. That is the cycle in which the start bit has reached the lowest position of the 11-bit shift register.
- R6: The parity mode input selects the check: 1 means the data bits plus the parity bit must hold an odd number of ones, and 0 means even. The mode is captured when the start is detected. A mismatch sets the parity flag along with ready.
- R7: A stop bit sampled as 0 sets the framing flag along with ready. The byte is still delivered.
- R8: If a character completes while ready is still 1, the overrun flag is set. The holding register, parity flag and framing flag keep the values of the unread byte.
- R9: A high-to-low transition of the read strobe copies the holding register to the read-data output on the next cycle. It also clears ready and all three error flags. Holding the strobe low causes no further read, and read data changes only after such a transition.
- R10: Characters sent back to back, each with a single stop bit, are all received in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Serial line, high when idle |
| odd_mode | input | 1 | Parity mode: 1 odd, 0 even |
| rd_n | input | 1 | Read strobe, active low, acts on its falling edge |
| rd_data | output | 8 | Byte latched by the last read |
| byte_ready | output | 1 | A received byte waits to be read |
| parity_fault | output | 1 | Parity mismatch in the waiting byte |
| frame_fault | output | 1 | Stop bit of the waiting byte was 0 |
| overrun_fault | output | 1 | A character was lost because the last byte was unread |

## Verification
Characters with alternating, all-zero, all-one and nibble-mixed data are sent with bit times of exactly 16 master cycles. These show whether bit order and the midpoint sampling grid are right. A reference model compares every output on every cycle, so if ready rises one cycle early or late, that is caught. Sending each wrong parity under both modes tells a mode error apart from an accumulation error. A low stop bit followed by a line held low tests both the framing flag and the rule that only an edge starts a character. A seven-cycle low pulse tests the start-bit rejection. Sending two characters without a read, holding the read strobe low across a character, and sending characters back to back test overrun, single-edge reads and recovery between characters.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_OVS    = 16;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_HUNT  = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic ready;
        logic parity;
        logic framing;
        logic overrun;
    } rx_flags_t;

    // start + data + parity + stop
    function automatic int unsigned frame_bits(int unsigned dw);
        return dw + 3;
    endfunction

    // true for the sample indices that carry data bits
    function automatic logic is_data_slot(int unsigned idx, int unsigned dw);
        return (idx >= 1) && (idx <= dw);
    endfunction

endpackage

// File: rtl/rx_start_ctl.sv
module rx_start_ctl
    import serial_rx_pkg::*;
#(
    parameter int unsigned OVS = DEF_OVS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_in,
    input  logic      frame_done,
    output rx_state_e state_q,
    output logic      baud_tick,
    output logic      hunt_start
);

    localparam int unsigned CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] CONFIRM = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVS - 1);

    logic             rx_d;
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] div_d;
    rx_state_e        state_d;

    always_comb begin
        state_d    = state_q;
        div_d      = div_q;
        baud_tick  = 1'b0;
        hunt_start = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (rx_d && !rx_in) begin
                    hunt_start = 1'b1;
                    state_d    = RX_HUNT;
                    div_d      = CNT_W'(1);
                end
            end
            RX_HUNT: begin
                if (rx_in) begin
                    state_d = RX_IDLE;
                end else if (div_q == CONFIRM) begin
                    baud_tick = 1'b1;
                    state_d   = RX_SHIFT;
                    div_d     = '0;
                end else begin
                    div_d = div_q + CNT_W'(1);
                end
            end
            RX_SHIFT: begin
                if (frame_done) begin
                    state_d = RX_IDLE;
                    div_d   = '0;
                end else if (div_q == LAST) begin
                    baud_tick = 1'b1;
                    div_d     = '0;
                end else begin
                    div_d = div_q + CNT_W'(1);
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_d    <= 1'b1;
            div_q   <= '0;
            state_q <= RX_IDLE;
        end else begin
            rx_d    <= rx_in;
            div_q   <= div_d;
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/rx_frame_shift.sv
module rx_frame_shift
    import serial_rx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    input  logic              odd_mode,
    input  logic              hunt_start,
    input  logic              baud_tick,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              parity_bad,
    output logic              stop_bit
);

    localparam int unsigned FRAME_W = frame_bits(DATA_W);
    localparam int unsigned IDX_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sr_q;
    logic [IDX_W-1:0]   idx_q;
    logic               acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '1;
            idx_q <= '0;
            acc_q <= 1'b0;
        end else if (hunt_start) begin
            sr_q  <= '1;
            idx_q <= '0;
            acc_q <= odd_mode;
        end else if (baud_tick) begin
            sr_q  <= {rx_in, sr_q[FRAME_W-1:1]};
            idx_q <= idx_q + IDX_W'(1);
            if (is_data_slot(int'(idx_q), DATA_W)) begin
                acc_q <= acc_q ^ rx_in;
            end
        end
    end

    // preset ones: bit 0 goes low only once the start bit reaches it
    assign frame_done = ~sr_q[0];
    assign frame_data = sr_q[DATA_W:1];
    assign parity_bad = acc_q ^ sr_q[DATA_W+1];
    assign stop_bit   = sr_q[FRAME_W-1];

endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs
    import serial_rx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              parity_bad,
    input  logic              stop_bit,
    input  logic              rd_n,
    output logic [DATA_W-1:0] rd_data,
    output rx_flags_t         flags_q
);

    logic              rd_d;
    logic              rd_fall;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] hold_d;
    rx_flags_t         flags_d;

    always_comb begin
        rd_fall = rd_d & ~rd_n;
        flags_d = flags_q;
        hold_d  = hold_q;
        if (rd_fall) begin
            flags_d = '0;
        end
        if (commit) begin
            if (flags_d.ready) begin
                flags_d.overrun = 1'b1;
            end else begin
                flags_d.ready   = 1'b1;
                flags_d.parity  = parity_bad;
                flags_d.framing = ~stop_bit;
                hold_d          = frame_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_d    <= 1'b1;
            hold_q  <= '0;
            flags_q <= '0;
            rd_data <= '0;
        end else begin
            rd_d    <= rd_n;
            hold_q  <= hold_d;
            flags_q <= flags_d;
            if (rd_fall) begin
                rd_data <= hold_q;
            end
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned OVS    = DEF_OVS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    input  logic              odd_mode,
    input  logic              rd_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              byte_ready,
    output logic              parity_fault,
    output logic              frame_fault,
    output logic              overrun_fault
);

    rx_state_e         ctl_state;
    logic              baud_tick;
    logic              hunt_start;
    logic              frame_done;
    logic              commit;
    logic [DATA_W-1:0] frame_data;
    logic              parity_bad;
    logic              stop_bit;
    rx_flags_t         flags;

    rx_start_ctl #(.OVS(OVS)) i_ctl (
        .clk        (clk),
        .rst        (rst),
        .rx_in      (rx_in),
        .frame_done (frame_done),
        .state_q    (ctl_state),
        .baud_tick  (baud_tick),
        .hunt_start (hunt_start)
    );

    rx_frame_shift #(.DATA_W(DATA_W)) i_shift (
        .clk        (clk),
        .rst        (rst),
        .rx_in      (rx_in),
        .odd_mode   (odd_mode),
        .hunt_start (hunt_start),
        .baud_tick  (baud_tick),
        .frame_done (frame_done),
        .frame_data (frame_data),
        .parity_bad (parity_bad),
        .stop_bit   (stop_bit)
    );

    assign commit = (ctl_state == RX_SHIFT) && frame_done;

    rx_hold_regs #(.DATA_W(DATA_W)) i_hold (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .frame_data (frame_data),
        .parity_bad (parity_bad),
        .stop_bit   (stop_bit),
        .rd_n       (rd_n),
        .rd_data    (rd_data),
        .flags_q    (flags)
    );

    assign byte_ready    = flags.ready;
    assign parity_fault  = flags.parity;
    assign frame_fault   = flags.framing;
    assign overrun_fault = flags.overrun;

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker
    import serial_rx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned OVS    = DEF_OVS
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_in,
    input logic              rd_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              byte_ready,
    input logic              parity_fault,
    input logic              frame_fault,
    input logic              overrun_fault,
    input rx_state_e         state,
    input logic              baud_tick,
    input logic              commit
);

    localparam int unsigned GAP_W = $clog2(OVS) + 1;

    logic             rd_d_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_d_q <= 1'b1;
            gap_q  <= '0;
        end else begin
            rd_d_q <= rd_n;
            if (baud_tick) begin
                gap_q <= '0;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

    AST_HUNT_ABORT: assert property (@(posedge clk) disable iff (rst)
        (state == RX_HUNT && rx_in) |=> (state == RX_IDLE)); // R3

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && state == RX_SHIFT) |-> (gap_q == GAP_W'(OVS - 1))); // R4

    AST_READY_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_ready) |-> $past(commit)); // R5

    AST_FLAGS_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        (parity_fault || frame_fault) |-> byte_ready); // R6, R7

    AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_fault) |-> $past(byte_ready)); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_d_q && !rd_n && !commit) |=> (!byte_ready && !overrun_fault)); // R9

    AST_DATA_ON_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> $past(rd_d_q && !rd_n)); // R9

endmodule

bind serial_rx_core serial_rx_checker #(.DATA_W(DATA_W), .OVS(OVS)) i_serial_rx_checker (
    .clk           (clk),
    .rst           (rst),
    .rx_in         (rx_in),
    .rd_n          (rd_n),
    .rd_data       (rd_data),
    .byte_ready    (byte_ready),
    .parity_fault  (parity_fault),
    .frame_fault   (frame_fault),
    .overrun_fault (overrun_fault),
    .state         (ctl_state),
    .baud_tick     (baud_tick),
    .commit        (commit)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst      = 1'b1;
    logic       rx_in    = 1'b1;
    logic       odd_mode = 1'b0;
    logic       rd_n     = 1'b1;
    logic [7:0] rd_data;
    logic       byte_ready, parity_fault, frame_fault, overrun_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    serial_rx_core i_serial_rx_core (
        .clk           (clk),
        .rst           (rst),
        .rx_in         (rx_in),
        .odd_mode      (odd_mode),
        .rd_n          (rd_n),
        .rd_data       (rd_data),
        .byte_ready    (byte_ready),
        .parity_fault  (parity_fault),
        .frame_fault   (frame_fault),
        .overrun_fault (overrun_fault)
    );

    // ---------------- behavioural reference model ----------------
    int         m_st;      // 0 waiting, 1 confirming start, 2 collecting
    int         m_low;
    int         m_phase;
    bit         m_bits[$];
    bit         m_prev_rx, m_prev_rd, m_odd, m_valid;
    logic [7:0] m_hold, m_data;
    bit         m_ready, m_perr, m_ferr, m_ovr;
    bit         m_fall, m_commit, m_par;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_low = 0; m_phase = 0; m_bits = {};
            m_prev_rx = 1; m_prev_rd = 1; m_odd = 0;
            m_hold = 0; m_data = 0;
            m_ready = 0; m_perr = 0; m_ferr = 0; m_ovr = 0;
            m_valid = 1;
        end else begin
            m_fall   = m_prev_rd && !rd_n;
            m_commit = 0;
            if (m_st == 2 && m_bits.size() == 11) begin
                m_commit = 1;
                m_st = 0;
            end else if (m_st == 0) begin
                if (m_prev_rx && !rx_in) begin
                    m_st = 1; m_low = 1; m_odd = odd_mode;
                end
            end else if (m_st == 1) begin
                if (rx_in) m_st = 0;
                else if (m_low == 7) begin
                    m_st = 2; m_bits = {rx_in}; m_phase = 0;
                end else m_low++;
            end else begin
                m_phase++;
                if (m_phase == 16) begin
                    m_phase = 0;
                    m_bits.push_back(rx_in);
                end
            end
            if (m_fall) begin
                m_data = m_hold;
                m_ready = 0; m_perr = 0; m_ferr = 0; m_ovr = 0;
            end
            if (m_commit) begin
                if (m_ready) m_ovr = 1;
                else begin
                    for (int i = 0; i < 8; i++) m_hold[i] = m_bits[1+i];
                    m_par = m_odd;
                    for (int i = 1; i <= 9; i++) m_par = m_par ^ m_bits[i];
                    m_perr  = m_par;
                    m_ferr  = !m_bits[10];
                    m_ready = 1;
                end
            end
            m_prev_rx = rx_in;
            m_prev_rd = rd_n;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            check("R9 model rd_data", 32'(rd_data), 32'(m_data));
            check("R5 model byte_ready", 32'(byte_ready), 32'(m_ready));
            check("R6 model parity_fault", 32'(parity_fault), 32'(m_perr));
            check("R7 model frame_fault", 32'(frame_fault), 32'(m_ferr));
            check("R8 model overrun_fault", 32'(overrun_fault), 32'(m_ovr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(bit b);
        rx_in = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] d, bit good_par, bit stop);
        bit p;
        p = odd_mode ? ~^d : ^d;
        if (!good_par) p = ~p;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        drive_bit(p);
        drive_bit(stop);
    endtask

    task automatic pulse_read();
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] b2b [3];
        b2b[0] = 8'h00; b2b[1] = 8'hFF; b2b[2] = 8'h81;

        idle(3);
        check("R1 rd_data in reset", 32'(rd_data), 0);
        check("R1 ready in reset", 32'(byte_ready), 0);
        check("R1 flags in reset", 32'({parity_fault, frame_fault, overrun_fault}), 0);
        rst = 1'b0;
        idle(20);
        check("R1 ready after reset", 32'(byte_ready), 0);

        // R4 R5: even mode, alternating data
        odd_mode = 1'b0;
        send_frame(8'hA5, 1, 1);
        idle(4);
        check("R5 ready after frame", 32'(byte_ready), 1);
        check("R6 even good parity", 32'(parity_fault), 0);
        pulse_read();
        check("R4 data A5", 32'(rd_data), 32'h A5);
        check("R9 ready cleared", 32'(byte_ready), 0);

        // R6: odd mode
        odd_mode = 1'b1;
        send_frame(8'h3C, 1, 1);
        idle(4);
        check("R6 odd good parity", 32'(parity_fault), 0);
        pulse_read();
        check("R4 data 3C", 32'(rd_data), 32'h3C);
        send_frame(8'h3C, 0, 1);
        idle(4);
        check("R6 odd bad parity", 32'(parity_fault), 1);
        pulse_read();
        check("R9 parity cleared", 32'(parity_fault), 0);
        odd_mode = 1'b0;
        send_frame(8'h0F, 0, 1);
        idle(4);
        check("R6 even bad parity", 32'(parity_fault), 1);
        pulse_read();
        check("R6 data kept 0F", 32'(rd_data), 32'h0F);

        // R7 then R2: low stop bit, line stays low
        send_frame(8'h55, 1, 0);
        idle(4);
        check("R7 framing flag", 32'(frame_fault), 1);
        pulse_read();
        check("R7 data 55", 32'(rd_data), 32'h55);
        check("R9 framing cleared", 32'(frame_fault), 0);
        idle(48);
        check("R2 no start without edge", 32'(byte_ready), 0);
        rx_in = 1'b1;
        idle(40);
        check("R2 still idle", 32'(byte_ready), 0);

        // R3: short low pulse
        rx_in = 1'b0;
        idle(7);
        rx_in = 1'b1;
        idle(200);
        check("R3 glitch rejected", 32'(byte_ready), 0);
        send_frame(8'hC3, 1, 1);
        idle(4);
        check("R3 recovers", 32'(byte_ready), 1);
        pulse_read();
        check("R3 data C3", 32'(rd_data), 32'hC3);

        // R8: overrun
        send_frame(8'h12, 1, 1);
        send_frame(8'h34, 0, 1);
        idle(4);
        check("R8 overrun flag", 32'(overrun_fault), 1);
        check("R8 parity of old byte kept", 32'(parity_fault), 0);
        pulse_read();
        check("R8 old byte kept", 32'(rd_data), 32'h12);
        check("R9 overrun cleared", 32'(overrun_fault), 0);

        // R9: strobe held low reads once
        send_frame(8'h6E, 1, 1);
        idle(4);
        rd_n = 1'b0;
        idle(4);
        check("R9 held read data", 32'(rd_data), 32'h6E);
        send_frame(8'h91, 1, 1);
        idle(4);
        check("R9 no second read", 32'(byte_ready), 1);
        check("R9 data unchanged", 32'(rd_data), 32'h6E);
        rd_n = 1'b1;
        idle(2);
        pulse_read();
        check("R9 next byte 91", 32'(rd_data), 32'h91);

        // R10: back-to-back characters
        fork
            begin
                send_frame(b2b[0], 1, 1);
                send_frame(b2b[1], 1, 1);
                send_frame(b2b[2], 1, 1);
            end
            begin
                for (int k = 0; k < 3; k++) begin
                    while (!byte_ready) @(negedge clk);
                    pulse_read();
                    check("R10 back-to-back byte", 32'(rd_data), 32'(b2b[k]));
                end
            end
        join
        idle(40);
        check("R10 no extra byte", 32'(byte_ready), 0);

        finish_run();
    end

endmodule